// File: doc/BRIEF.md
# Two-Channel Scatter-Gather DMA Register Bank

This block holds the software-visible control and status state for a DMA engine with two channels. Each channel has four live registers: a control word, a status word, a current-descriptor pointer and a tail-descriptor pointer. Software reaches them over a simple request/response bus that carries a byte address. A separate descriptor engine sees each channel's run, halted and idle state. It gets a one-cycle start request whenever software moves the tail pointer of channel 0. It reports completion, delay, halt and idle events back into the status words.

Several behaviours are fixed by hardware. Tail-pointer operation is always enabled. A soft reset requested through the control word stays in force until software reads the control word. While it is in force, further control writes reinitialise the channel again rather than start it. The interrupt-pending field of the status word is cleared by writing ones. Interrupt coalescing counters are not kept here, so their fields read as zero.

Top module: `dma_ctl_regs`

## Requirements
- R1: After hardware reset each channel's control word reads 0x00010000 (completion threshold of one in bits 23:16), its status word reads 0x00000001 (halted), its pointers read 0, ch_run and ch_idle are 0, ch_halted is all ones and start_req is 0.
- R2: The channel is (address / 0x30) mod 2 and the register is (address mod 0x30) / 4. Offset 0x00 is control, 0x04 status, 0x08 current descriptor and 0x10 tail descriptor, so address 0x68 aliases channel 0's current pointer and 0x38 is channel 1's current pointer.
- R3: Any other offset in a window (for example 0x0C, 0x1C, 0x2C) reads as zero, and a write to it changes nothing.
- R4: A read request is answered with rsp_valid high and the data in the cycle after the request. A write request never raises rsp_valid.
- R5: Every control write stores the written value with bit 1 (tail-pointer mode) forced to 1 and bit 2 (soft reset) kept at 1 if it was already 1.
- R6: A control write whose resulting bit 2 is 1 reloads control to 0x00010006 and status to 0x00000001. It leaves both pointers unchanged and does not start the channel, including when bit 0 is written as 1.
- R7: A control read returns the stored value with bit 2 reading 0, and it clears bit 2 in the register.
- R8: A control write with bit 0 (run) set and no soft reset in force clears status bits 0 (halted) and 1 (idle).
- R9: In a status write, each 1 in bits 14:12 clears that pending bit. No other status bit is changed by a write, and bits 31:16 always read 0.
- R10: A tail write stores the value and clears status bit 1 (idle). On channel 0 it also raises start_req for exactly the one cycle after the write. A tail write on channel 1 never raises start_req.
- R11: The per-channel engine inputs set status bits as follows: completion sets bit 12, delay sets bit 13, halt sets bit 0 and idle sets bit 1. A set wins over a write-one-to-clear in the same cycle, and events are dropped in a cycle where a soft reset reinitialises the channel.
- R12: ch_run[n] follows control bit 0 of channel n, and ch_halted[n] and ch_idle[n] follow status bits 0 and 1 of channel n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W (8) | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response strobe, one cycle after the read |
| rsp_rdata | output | 32 | Read response data |
| eng_cmpl | input | N_CH (2) | Completion event per channel |
| eng_dly | input | N_CH (2) | Delay event per channel |
| eng_halt | input | N_CH (2) | Halt event per channel |
| eng_idle | input | N_CH (2) | Idle (tail reached) event per channel |
| ch_run | output | N_CH (2) | Run bit per channel |
| ch_halted | output | N_CH (2) | Halted status per channel |
| ch_idle | output | N_CH (2) | Idle status per channel |
| start_req | output | 1 | One-cycle start request after a channel 0 tail write |

## Verification
The assertions check, on every cycle, the rules that follow from a single access. A control write always leaves the tail-pointer mode bit set. A control read always leaves soft reset clear. A soft-reset write always lands status on halted. A write-one-to-clear drops its bit unless a completion event arrives with it. A completion event sets its bit. A read is answered exactly one cycle later, and start_req only follows a channel 0 tail write. Other behaviours need a sequence of accesses and only the bench scenarios can show them. These are address aliasing, unimplemented offsets reading zero, soft reset staying in force across control writes until a read, pointers surviving a soft reset, and the order in which events and clears combine over several cycles.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;

    localparam int REG_W = 32;

    // control bit positions
    localparam int CB_RUN      = 0;
    localparam int CB_TAILMODE = 1;
    localparam int CB_SRST     = 2;

    // status bit positions
    localparam int SB_HALT = 0;
    localparam int SB_IDLE = 1;
    localparam int SB_CMPL = 12;
    localparam int SB_DLY  = 13;
    localparam int SB_IRQ_LO = 12;
    localparam int SB_IRQ_HI = 14;

    localparam logic [REG_W-1:0] CTRL_RST_VAL  = 32'h0001_0000;
    localparam logic [REG_W-1:0] STAT_RST_VAL  = 32'h0000_0001;
    localparam logic [REG_W-1:0] CTRL_SRST_VAL = CTRL_RST_VAL
                                               | (REG_W'(1) << CB_TAILMODE)
                                               | (REG_W'(1) << CB_SRST);

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_CUR  = 2'd2,
        SEL_TAIL = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [REG_W-1:0] ctrl;
        logic [REG_W-1:0] stat;
        logic [REG_W-1:0] cur;
        logic [REG_W-1:0] tail;
    } chan_state_t;

    typedef struct packed {
        logic             valid;
        logic [REG_W-1:0] data;
    } rsp_t;

endpackage

// File: rtl/dma_addr_map.sv
module dma_addr_map
    import dma_ctl_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int WIN_BYTES = 48,
    parameter int N_CH      = 2,
    localparam int CH_W     = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [CH_W-1:0]   ch_idx,
    output reg_sel_e          sel,
    output logic              hit
);

    localparam logic [ADDR_W-1:0] WIN = ADDR_W'(WIN_BYTES);
    localparam logic [ADDR_W-1:0] NCH = ADDR_W'(N_CH);

    logic [ADDR_W-1:0] win_num;
    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-3:0] word;

    always_comb begin
        win_num = addr / WIN;
        offset  = addr % WIN;
        word    = offset[ADDR_W-1:2];
        ch_idx  = CH_W'(win_num % NCH);
        hit     = 1'b1;
        sel     = SEL_CTRL;
        if (word == (ADDR_W-2)'(0)) begin
            sel = SEL_CTRL;
        end else if (word == (ADDR_W-2)'(1)) begin
            sel = SEL_STAT;
        end else if (word == (ADDR_W-2)'(2)) begin
            sel = SEL_CUR;
        end else if (word == (ADDR_W-2)'(4)) begin
            sel = SEL_TAIL;
        end else begin
            hit = 1'b0;
        end
    end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_ctl_pkg::*;
#(
    parameter bit START_EN = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  reg_sel_e         sel,
    input  logic [REG_W-1:0] wdata,
    input  logic             evt_cmpl,
    input  logic             evt_dly,
    input  logic             evt_halt,
    input  logic             evt_idle,
    output logic [REG_W-1:0] rdata,
    output logic             run,
    output logic             halted,
    output logic             idle,
    output logic             start_req
);

    chan_state_t      st_d, st_q;
    logic             start_d, start_q;
    logic [REG_W-1:0] ctrl_w;
    logic             srst_now;

    always_comb begin
        st_d     = st_q;
        start_d  = 1'b0;
        ctrl_w   = wdata | (REG_W'(1) << CB_TAILMODE)
                 | (st_q.ctrl & (REG_W'(1) << CB_SRST));
        srst_now = wr_en && (sel == SEL_CTRL) && ctrl_w[CB_SRST];

        if (wr_en) begin
            case (sel)
                SEL_CTRL: begin
                    if (ctrl_w[CB_SRST]) begin
                        st_d.ctrl = CTRL_SRST_VAL;
                        st_d.stat = STAT_RST_VAL;
                    end else begin
                        st_d.ctrl = ctrl_w;
                        if (ctrl_w[CB_RUN]) begin
                            st_d.stat[SB_HALT] = 1'b0;
                            st_d.stat[SB_IDLE] = 1'b0;
                        end
                    end
                end
                SEL_STAT: begin
                    st_d.stat[SB_IRQ_HI:SB_IRQ_LO] = st_q.stat[SB_IRQ_HI:SB_IRQ_LO]
                                                   & ~wdata[SB_IRQ_HI:SB_IRQ_LO];
                end
                SEL_CUR: begin
                    st_d.cur = wdata;
                end
                default: begin
                    st_d.tail          = wdata;
                    st_d.stat[SB_IDLE] = 1'b0;
                    start_d            = START_EN;
                end
            endcase
        end

        if (rd_en && (sel == SEL_CTRL)) begin
            st_d.ctrl[CB_SRST] = 1'b0;
        end

        if (!srst_now) begin
            if (evt_cmpl) st_d.stat[SB_CMPL] = 1'b1;
            if (evt_dly)  st_d.stat[SB_DLY]  = 1'b1;
            if (evt_halt) st_d.stat[SB_HALT] = 1'b1;
            if (evt_idle) st_d.stat[SB_IDLE] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '{ctrl: CTRL_RST_VAL, stat: STAT_RST_VAL, cur: '0, tail: '0};
            start_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            start_q <= start_d;
        end
    end

    always_comb begin
        case (sel)
            SEL_CTRL: rdata = st_q.ctrl & ~(REG_W'(1) << CB_SRST);
            SEL_STAT: rdata = st_q.stat;
            SEL_CUR:  rdata = st_q.cur;
            default:  rdata = st_q.tail;
        endcase
    end

    assign run       = st_q.ctrl[CB_RUN];
    assign halted    = st_q.stat[SB_HALT];
    assign idle      = st_q.stat[SB_IDLE];
    assign start_req = start_q;

    // R5
    tailmode_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_CTRL) |=> st_q.ctrl[CB_TAILMODE]);

    // R7
    srst_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_CTRL) |=> !st_q.ctrl[CB_SRST]);

    // R6
    srst_stat_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_CTRL && (wdata[CB_SRST] || st_q.ctrl[CB_SRST]))
        |=> (st_q.stat == STAT_RST_VAL && !st_q.ctrl[CB_RUN]));

    // R9
    w1c_cmpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_STAT && wdata[SB_CMPL] && !evt_cmpl)
        |=> !st_q.stat[SB_CMPL]);

    // R11
    cmpl_event_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_cmpl && !(wr_en && sel == SEL_CTRL && (wdata[CB_SRST] || st_q.ctrl[CB_SRST])))
        |=> st_q.stat[SB_CMPL]);

endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
    import dma_ctl_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int WIN_BYTES = 48,
    parameter int N_CH      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [REG_W-1:0]  req_wdata,
    output logic              rsp_valid,
    output logic [REG_W-1:0]  rsp_rdata,
    input  logic [N_CH-1:0]   eng_cmpl,
    input  logic [N_CH-1:0]   eng_dly,
    input  logic [N_CH-1:0]   eng_halt,
    input  logic [N_CH-1:0]   eng_idle,
    output logic [N_CH-1:0]   ch_run,
    output logic [N_CH-1:0]   ch_halted,
    output logic [N_CH-1:0]   ch_idle,
    output logic              start_req
);

    localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1;

    logic [CH_W-1:0]  ch_idx;
    reg_sel_e         sel;
    logic             hit;
    logic [REG_W-1:0] chan_rdata [N_CH];
    logic [N_CH-1:0]  chan_start;
    rsp_t             rsp_d, rsp_q;

    dma_addr_map #(
        .ADDR_W    (ADDR_W),
        .WIN_BYTES (WIN_BYTES),
        .N_CH      (N_CH)
    ) i_map (
        .addr   (req_addr),
        .ch_idx (ch_idx),
        .sel    (sel),
        .hit    (hit)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_chan
        logic sel_this;
        assign sel_this = req_valid && hit && (ch_idx == CH_W'(c));

        dma_chan_regs #(
            .START_EN (c == 0)
        ) i_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (sel_this && req_write),
            .rd_en     (sel_this && !req_write),
            .sel       (sel),
            .wdata     (req_wdata),
            .evt_cmpl  (eng_cmpl[c]),
            .evt_dly   (eng_dly[c]),
            .evt_halt  (eng_halt[c]),
            .evt_idle  (eng_idle[c]),
            .rdata     (chan_rdata[c]),
            .run       (ch_run[c]),
            .halted    (ch_halted[c]),
            .idle      (ch_idle[c]),
            .start_req (chan_start[c])
        );
    end

    always_comb begin
        rsp_d.valid = req_valid && !req_write;
        rsp_d.data  = '0;
        if (req_valid && !req_write && hit) begin
            rsp_d.data = chan_rdata[ch_idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_rdata = rsp_q.data;
    assign start_req = |chan_start;

    // R4
    read_rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    // R4
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);

    // R10
    start_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |-> $past(req_valid && req_write && hit && sel == SEL_TAIL
                            && ch_idx == CH_W'(0)));

endmodule

// File: tb/test_dma_ctl_regs.sv
module test_dma_ctl_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [1:0]  eng_cmpl = '0, eng_dly = '0, eng_halt = '0, eng_idle = '0;
    logic [1:0]  ch_run, ch_halted, ch_idle;
    logic        start_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic last_start, last_rspv;
    logic [31:0] rd_val;

    always #5 clk = ~clk;

    dma_ctl_regs i_dma_ctl_regs (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .eng_cmpl(eng_cmpl), .eng_dly(eng_dly),
        .eng_halt(eng_halt), .eng_idle(eng_idle),
        .ch_run(ch_run), .ch_halted(ch_halted), .ch_idle(ch_idle),
        .start_req(start_req)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 8'h00, 32'h0001_0000, 4'd1},  // R1 ch0 control
        '{1'b0, 8'h04, 32'h0000_0001, 4'd1},  // R1 ch0 status
        '{1'b0, 8'h34, 32'h0000_0001, 4'd1},  // R1 ch1 status
        '{1'b0, 8'h08, 32'h0000_0000, 4'd1},  // R1 pointer
        '{1'b1, 8'h08, 32'h1000_0040, 4'd2},  // R2 write ch0 cur
        '{1'b0, 8'h08, 32'h1000_0040, 4'd2},  // R2
        '{1'b0, 8'h68, 32'h1000_0040, 4'd2},  // R2 alias
        '{1'b0, 8'h38, 32'h0000_0000, 4'd2},  // R2 ch1 cur separate
        '{1'b1, 8'h0C, 32'hDEAD_BEEF, 4'd3},  // R3 hole write
        '{1'b0, 8'h0C, 32'h0000_0000, 4'd3},  // R3
        '{1'b0, 8'h1C, 32'h0000_0000, 4'd3},  // R3
        '{1'b1, 8'h00, 32'h0000_0001, 4'd8},  // R8 run ch0
        '{1'b0, 8'h00, 32'h0000_0003, 4'd5},  // R5 mode forced
        '{1'b0, 8'h04, 32'h0000_0000, 4'd8},  // R8 halted cleared
        '{1'b1, 8'h40, 32'h0000_2000, 4'd10}, // R10 ch1 tail
        '{1'b0, 8'h40, 32'h0000_2000, 4'd10}, // R10
        '{1'b1, 8'h30, 32'h0000_0005, 4'd6},  // R6 soft reset + run ch1
        '{1'b0, 8'h34, 32'h0000_0001, 4'd6},  // R6 status reloaded
        '{1'b0, 8'h30, 32'h0001_0002, 4'd7},  // R7 reads bit2 clear
        '{1'b0, 8'h30, 32'h0001_0002, 4'd7},  // R7
        '{1'b0, 8'h40, 32'h0000_2000, 4'd6},  // R6 pointer kept
        '{1'b1, 8'h30, 32'h0000_0001, 4'd8},  // R8 run ch1
        '{1'b0, 8'h34, 32'h0000_0000, 4'd8},  // R8
        '{1'b1, 8'h04, 32'h0000_0003, 4'd9},  // R9 non-irq bits
        '{1'b0, 8'h04, 32'h0000_0000, 4'd9},  // R9 unchanged
        '{1'b0, 8'h2C, 32'h0000_0000, 4'd3}   // R3
    };

    task automatic check(input int r, input logic [31:0] act, input logic [31:0] exp,
                         input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", r, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        last_start = start_req;
        last_rspv  = rsp_valid;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        last_rspv = rsp_valid;
        d = rsp_rdata;
    endtask

    task automatic pulse_evt(input logic [1:0] c, input logic [1:0] dl,
                             input logic [1:0] h, input logic [1:0] i);
        @(negedge clk);
        eng_cmpl = c; eng_dly = dl; eng_halt = h; eng_idle = i;
        @(negedge clk);
        eng_cmpl = '0; eng_dly = '0; eng_halt = '0; eng_idle = '0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1 outputs during and after reset
        check(1, {30'd0, ch_halted}, 32'd3, "halted in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(1, {28'd0, ch_run, ch_idle}, 32'd0, "run/idle after reset");
        check(1, {31'd0, start_req}, 32'd0, "start after reset");

        for (int k = 0; k < NV; k++) begin
            if (TBL[k].wr) begin
                do_write(TBL[k].addr, TBL[k].data);
            end else begin
                do_read(TBL[k].addr, rd_val);
                check(int'(TBL[k].req), rd_val, TBL[k].data, $sformatf("table row %0d", k));
            end
        end

        // R4 response timing
        do_write(8'h08, 32'h1000_0080);
        check(4, {31'd0, last_rspv}, 32'd0, "rsp after write");
        do_read(8'h08, rd_val);
        check(4, {31'd0, last_rspv}, 32'd1, "rsp after read");
        check(4, rd_val, 32'h1000_0080, "read data");

        // R12 state outputs
        check(12, {26'd0, ch_run, ch_halted, ch_idle}, 32'b11_00_00, "run/halt/idle");

        // R10 start pulse only for channel 0
        do_write(8'h10, 32'h0000_3000);
        check(10, {31'd0, last_start}, 32'd1, "ch0 tail start");
        @(negedge clk);
        check(10, {31'd0, start_req}, 32'd0, "start one cycle");
        do_write(8'h40, 32'h0000_4000);
        check(10, {31'd0, last_start}, 32'd0, "ch1 tail no start");

        // R11 events and R9 write-one-to-clear
        pulse_evt(2'b01, 2'b00, 2'b00, 2'b00);
        do_read(8'h04, rd_val);
        check(11, rd_val, 32'h0000_1000, "completion set");
        pulse_evt(2'b00, 2'b01, 2'b00, 2'b00);
        do_read(8'h04, rd_val);
        check(11, rd_val, 32'h0000_3000, "delay set");
        do_write(8'h04, 32'h0000_1000);
        do_read(8'h04, rd_val);
        check(9, rd_val, 32'h0000_2000, "w1c completion");
        pulse_evt(2'b00, 2'b00, 2'b00, 2'b01);
        check(12, {31'd0, ch_idle[0]}, 32'd1, "idle output");
        do_read(8'h04, rd_val);
        check(11, rd_val, 32'h0000_2002, "idle set");
        do_write(8'h10, 32'h0000_3100);
        check(10, {31'd0, ch_idle[0]}, 32'd0, "tail clears idle");
        pulse_evt(2'b00, 2'b00, 2'b10, 2'b00);
        check(12, {30'd0, ch_halted}, 32'b10, "ch1 halted output");

        // R11 set beats clear in the same cycle
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h04; req_wdata = 32'h0000_1000;
        eng_cmpl = 2'b01;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; eng_cmpl = '0;
        do_read(8'h04, rd_val);
        check(11, rd_val, 32'h0000_3000, "set wins over clear");

        // R6 soft reset held across control writes until a read
        do_write(8'h00, 32'h0000_0004);
        do_write(8'h00, 32'h0000_0001);
        check(6, {31'd0, ch_run[0]}, 32'd0, "no run while reset held");
        check(6, {31'd0, ch_halted[0]}, 32'd1, "halted while reset held");
        do_read(8'h04, rd_val);
        check(6, rd_val, 32'h0000_0001, "status reloaded");
        do_read(8'h08, rd_val);
        check(6, rd_val, 32'h1000_0080, "cur kept");
        do_read(8'h00, rd_val);
        check(7, rd_val, 32'h0001_0002, "control read");
        do_write(8'h00, 32'h0000_0001);
        check(8, {31'd0, ch_run[0]}, 32'd1, "run after read");
        check(8, {31'd0, ch_halted[0]}, 32'd0, "halt cleared after read");

        // R1 hardware reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(1, {26'd0, ch_run, ch_halted, ch_idle}, 32'b00_11_00, "reset outputs");
        rst_n = 1'b1;
        do_read(8'h10, rd_val);
        check(1, rd_val, 32'h0, "tail after reset");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule